// File: doc/BRIEF.md
# Shared-Ramp Multi-Channel Wilkinson Conversion Controller

This block is the digital side of a Wilkinson converter in which one voltage ramp and one counter serve every channel at the same time. A start command launches a conversion. The controller raises the ramp enable and runs a shared binary counter from zero up to full scale, presenting it to the channels in Gray code. Each channel has its own end-of-ramp comparator, seen here as one input bit. A channel stores the Gray-coded count on the first rising edge of its comparator. It also stores a gain-range bit that records whether the low-gain or the high-gain path was selected.

A conversion lasts 2^CW counter cycles. The default is 12 bits, 4096 cycles, which is about 82 µs at a 50 MHz counter clock. After the last count the controller drops the ramp enable. It raises a done flag and gives one write strobe so that event memory can store all the codes. A channel whose comparator never fires stores the full-scale code. A start request that arrives during a conversion is ignored.

Top module: `wilk_conv_ctrl`

## Requirements
- R1: After reset, busy_o, done_o and wr_o are 0, and every code and gain output is 0.
- R2: A start_i seen at a clock edge while no conversion is running begins a conversion. From the next cycle busy_o is 1, done_o is 0, and the counter holds 0.
- R3: The counter steps by one on each cycle of the conversion. A channel whose comparator is 1 in the cycle the counter holds v, and was 0 in the cycle before, stores the Gray code v ^ (v >> 1). Channel k's code sits at codes_o[k*CW +: CW].
- R4: Only the first rising comparator edge of a conversion is stored. Later edges in the same conversion leave the channel's code and gain unchanged.
- R5: At the moment of the latch, gain_o[k] takes the value of gain_i[k], where 1 selects low gain. Changes of gain_i[k] after that do not affect gain_o[k].
- R6: A channel that sees no rising edge up to full scale stores the Gray code of 2^CW-1. This includes a channel whose comparator was already 1 when the conversion started.
- R7: A conversion lasts exactly 2^CW cycles of busy_o. In the cycle after the counter held 2^CW-1, busy_o is 0 and done_o is 1, and done_o stays 1 until the next start. wr_o is 1 for exactly that first done cycle.
- R8: A start_i during a conversion is ignored. The conversion ends at the same cycle as it would have without that start, and the stored codes do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start-conversion request |
| cmp_i | input | NCH | End-of-ramp comparator outputs, one per channel |
| gain_i | input | NCH | Gain-range selection per channel (1 = low gain) |
| busy_o | output | 1 | Conversion running; doubles as the ramp enable |
| done_o | output | 1 | Conversion finished, codes valid |
| wr_o | output | 1 | One-cycle write strobe toward event memory |
| codes_o | output | NCH*CW | Latched Gray codes, channel k at [k*CW +: CW] |
| gain_o | output | NCH | Latched gain-range bits |

## Verification
The bench builds the block with NCH=4 and CW=6. A full conversion then takes only 64 cycles, so several complete conversions fit in one run. Each one runs to its true full-scale count and finishes with the real done and write-strobe timing. This makes it cheap to hit the edge cases directly: a latch at count 0, a latch at the last count, comparators that are already high at start, pulses that fall and rise again, and a restart straight from the done state.

// File: rtl/wilk_conv_pkg.sv
package wilk_conv_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_RUN  = 2'd1,
        SEQ_DONE = 2'd2
    } seq_state_e;

endpackage

// File: rtl/wilk_gray_counter.sv
module wilk_gray_counter #(
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic          en_i,
    output logic [CW-1:0] gray_o,
    output logic          last_o
);
    localparam logic [CW-1:0] FULL = {CW{1'b1}};

    logic [CW-1:0] bin_d, bin_q;

    always_comb begin
        bin_d = bin_q;
        if (clr_i)
            bin_d = '0;
        else if (en_i && (bin_q != FULL))
            bin_d = bin_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bin_q <= '0;
        else        bin_q <= bin_d;
    end

    assign gray_o = bin_q ^ (bin_q >> 1);
    assign last_o = (bin_q == FULL);

    // R3: the count advances by exactly one per running cycle
    a_r3_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !clr_i && !last_o) |=> (bin_q == $past(bin_q) + 1'b1));

    // R2: a clear request leaves the counter at zero
    a_r2_count_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (bin_q == '0));

endmodule

// File: rtl/wilk_chan_latch.sv
module wilk_chan_latch #(
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic          run_i,
    input  logic          last_i,
    input  logic [CW-1:0] gray_i,
    input  logic          cmp_i,
    input  logic          gain_i,
    output logic [CW-1:0] code_o,
    output logic          gain_o
);
    typedef struct packed {
        logic [CW-1:0] code;
        logic          gain;
        logic          hit;
        logic          prev;
    } chan_t;

    chan_t cur_q, nxt_d;
    logic  rise;

    assign rise = cmp_i & ~cur_q.prev;

    always_comb begin
        nxt_d      = cur_q;
        nxt_d.prev = cmp_i;
        if (clr_i) begin
            nxt_d.hit  = 1'b0;
            nxt_d.code = '0;
            nxt_d.gain = 1'b0;
        end else if (run_i && !cur_q.hit && (rise || last_i)) begin
            nxt_d.hit  = 1'b1;
            nxt_d.code = gray_i;
            nxt_d.gain = gain_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign code_o = cur_q.code;
    assign gain_o = cur_q.gain;

    // R4/R5: once stored, code and gain hold until the next clear
    a_r4_hold_after_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.hit && !clr_i) |=> ($stable(cur_q.code) && $stable(cur_q.gain) && cur_q.hit));

    // R6: every channel has stored a value by the end of the ramp
    a_r6_full_scale_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && last_i && !clr_i) |=> cur_q.hit);

endmodule

// File: rtl/wilk_conv_ctrl.sv
module wilk_conv_ctrl
    import wilk_conv_pkg::*;
#(
    parameter int NCH = 36,
    parameter int CW  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [NCH-1:0]    cmp_i,
    input  logic [NCH-1:0]    gain_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              wr_o,
    output logic [NCH*CW-1:0] codes_o,
    output logic [NCH-1:0]    gain_o
);
    typedef struct packed {
        seq_state_e st;
        logic       wr;
    } seq_t;

    seq_t          seq_q, seq_d;
    logic          accept;
    logic          running;
    logic          last;
    logic [CW-1:0] gray;

    assign running = (seq_q.st == SEQ_RUN);
    assign accept  = start_i && !running;

    always_comb begin
        seq_d    = seq_q;
        seq_d.wr = 1'b0;
        if (accept) begin
            seq_d.st = SEQ_RUN;
        end else if (running && last) begin
            seq_d.st = SEQ_DONE;
            seq_d.wr = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '{st: SEQ_IDLE, wr: 1'b0};
        else        seq_q <= seq_d;
    end

    wilk_gray_counter #(.CW(CW)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (accept),
        .en_i   (running),
        .gray_o (gray),
        .last_o (last)
    );

    for (genvar k = 0; k < NCH; k++) begin : g_chan
        wilk_chan_latch #(.CW(CW)) u_ch (
            .clk    (clk),
            .rst_n  (rst_n),
            .clr_i  (accept),
            .run_i  (running),
            .last_i (last),
            .gray_i (gray),
            .cmp_i  (cmp_i[k]),
            .gain_i (gain_i[k]),
            .code_o (codes_o[k*CW +: CW]),
            .gain_o (gain_o[k])
        );
    end

    assign busy_o = running;
    assign done_o = (seq_q.st == SEQ_DONE);
    assign wr_o   = seq_q.wr;

    // R2: an idle or done controller starts on request
    a_r2_start_runs: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> (busy_o && !done_o));

    // R8: a request during a conversion does not cut it short
    a_r8_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !last) |=> busy_o);

    // R7: the strobe accompanies the rise of done and lasts one cycle
    a_r7_wr_on_done_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> wr_o);
    a_r7_wr_single: assert property (@(posedge clk) disable iff (!rst_n)
        wr_o |=> !wr_o);
    a_r7_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> done_o);

endmodule

// File: tb/wilk_conv_ctrl_tb.sv
module wilk_conv_ctrl_tb;
    localparam int  NCH        = 4;
    localparam int  CW         = 6;
    localparam int  MAXC       = (1 << CW) - 1;
    localparam int  NONE       = -100;
    localparam time CLK_PERIOD = 20ns;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0;
    logic [NCH-1:0]    cmp_i = '0;
    logic [NCH-1:0]    gain_i = '0;
    logic              busy_o, done_o, wr_o;
    logic [NCH*CW-1:0] codes_o;
    logic [NCH-1:0]    gain_o;

    int n_checks = 0;
    int n_errors = 0;

    int r1 [NCH];
    int l1 [NCH];
    int r2 [NCH];
    bit glvl [NCH];
    int exp_c [NCH];

    always #(CLK_PERIOD/2) clk = ~clk;

    wilk_conv_ctrl #(.NCH(NCH), .CW(CW)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .cmp_i(cmp_i),
        .gain_i(gain_i), .busy_o(busy_o), .done_o(done_o), .wr_o(wr_o),
        .codes_o(codes_o), .gain_o(gain_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic int to_gray(input int v);
        return v ^ (v >> 1);
    endfunction

    function automatic bit cmp_at(input int k, input int c);
        bit h1 = (r1[k] != NONE) && (c >= r1[k]) && ((l1[k] == 0) || (c < r1[k] + l1[k]));
        bit h2 = (r2[k] != NONE) && (c >= r2[k]);
        return h1 || h2;
    endfunction

    // Runs one conversion with the pattern in r1/l1/r2/glvl; restarts at cycle smid (NONE = no extra start)
    task automatic run_conv(input string name, input int smid);
        for (int k = 0; k < NCH; k++) begin
            exp_c[k] = MAXC;
            for (int c = MAXC; c >= 0; c--)
                if (cmp_at(k, c) && !cmp_at(k, c - 1)) exp_c[k] = c;
        end
        @(negedge clk);
        for (int k = 0; k < NCH; k++) begin
            cmp_i[k]  = cmp_at(k, -1);
            gain_i[k] = glvl[k];
        end
        start_i = 1'b1;
        @(posedge clk);
        for (int cyc = 0; cyc <= MAXC; cyc++) begin
            @(negedge clk);
            start_i = (cyc == smid);
            for (int k = 0; k < NCH; k++) begin
                cmp_i[k]  = cmp_at(k, cyc);
                gain_i[k] = glvl[k] ^ (cyc > exp_c[k]);
            end
            if (cyc == 0) begin
                check(busy_o == 1'b1, "R2 busy after start", busy_o, 1);
                check(done_o == 1'b0, "R2 done cleared", done_o, 0);
            end
            if (cyc == MAXC) begin
                check(busy_o == 1'b1, "R7/R8 still busy at last count", busy_o, 1);
                check(done_o == 1'b0, "R7 no early done", done_o, 0);
            end
            @(posedge clk);
        end
        @(negedge clk);
        start_i = 1'b0;
        cmp_i   = '0;
        check(busy_o == 1'b0, "R7 busy falls", busy_o, 0);
        check(done_o == 1'b1, "R7 done rises", done_o, 1);
        check(wr_o == 1'b1, "R7 write strobe", wr_o, 1);
        for (int k = 0; k < NCH; k++) begin
            int act = int'(codes_o[k*CW +: CW]);
            int ex  = to_gray(exp_c[k]);
            check(act == ex, $sformatf("R3/R4/R6 %s ch%0d code", name, k), act, ex);
            check(gain_o[k] == glvl[k], $sformatf("R5 %s ch%0d gain", name, k), gain_o[k], glvl[k]);
        end
        @(negedge clk);
        check(wr_o == 1'b0, "R7 strobe single cycle", wr_o, 0);
        check(done_o == 1'b1, "R7 done held", done_o, 1);
    endtask

    task automatic t_reset();
        check(busy_o == 0 && done_o == 0 && wr_o == 0, "R1 control outputs", {busy_o, done_o, wr_o}, 0);
        check(codes_o == '0, "R1 codes", int'(codes_o != '0), 0);
        check(gain_o == '0, "R1 gains", int'(gain_o), 0);
    endtask

    // R3 R5 R6: distinct latch points, count 0, and a silent channel
    task automatic t_basic();
        r1 = '{5, 0, 40, NONE}; l1 = '{0, 0, 0, 0}; r2 = '{NONE, NONE, NONE, NONE};
        glvl = '{1, 0, 1, 1};
        run_conv("basic", NONE);
    endtask

    // R4 R6: pulse then second edge, last-count edge, already-high comparator
    task automatic t_edges();
        r1 = '{3, 62, MAXC, -1}; l1 = '{2, 0, 0, 0}; r2 = '{10, NONE, NONE, NONE};
        glvl = '{0, 1, 0, 1};
        run_conv("edges", NONE);
    endtask

    // R8: start request in mid conversion
    task automatic t_busy_start();
        r1 = '{17, 33, 1, 50}; l1 = '{0, 4, 0, 1}; r2 = '{NONE, 45, NONE, 55};
        glvl = '{1, 1, 0, 0};
        run_conv("busy_start", 20);
    endtask

    // R2: restart straight from the done state
    task automatic t_restart();
        r1 = '{NONE, 7, 63, 2}; l1 = '{0, 0, 0, 0}; r2 = '{NONE, NONE, NONE, NONE};
        glvl = '{0, 0, 1, 1};
        run_conv("restart", NONE);
    endtask

    initial begin
        fork
            begin
                #1ns;
                t_reset();
                repeat (3) @(posedge clk);
                @(negedge clk);
                rst_n = 1'b1;
                t_reset();
                t_basic();
                t_edges();
                t_busy_start();
                t_restart();
            end
            begin
                repeat (20000) @(posedge clk);
                n_checks++;
                n_errors++;
                $display("FAIL watchdog actual=timeout expected=finish");
            end
        join_any
        disable fork;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule